// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Two-Way Routing

This block collects 32 level-sensitive interrupt lines from peripherals and drives two CPU interrupt outputs. Software controls it through a small register bank on a simple 32-bit bus. The bus has a write strobe, a byte address and write data. Read data is combinational from the address.

Sources are switched on through a set port and switched off through a clear port. Each port acts only on the bits written as one. Bit 31 of the enable mask is a global gate for both outputs. A routing register holds one bit per source and picks the output that source drives. Software can read the synchronized raw line levels and the masked pending bits for each output. Pending bits are not latched: they follow the input levels.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the enable mask (address 0x34), the routing register (address 0x20) and both CPU outputs read as zero.
- R2: A write to address 0x34 sets each enable bit written as one. Enable bits written as zero keep their value. Reading 0x34 returns the whole mask, including bit 31.
- R3: A write to address 0x38 clears each enable bit written as one. Writing all ones clears the whole mask. Reading 0x38 returns zero.
- R4: While enable bit 31 is zero, both CPU outputs stay low, whatever the other enable bits and the inputs hold.
- R5: Routing bit k at address 0x20 steers source k. A value of 0 sends it to output 0, whose pending bits read at 0x00. A value of 1 sends it to output 1, whose pending bits read at 0x04.
- R6: Pending bits for output n are raw AND enable AND (routing selects n). They follow the input level, so a dropped input leaves pending with no write by software.
- R7: A change of the enable mask shows in the pending registers right after the write edge.
- R8: Address 0x30 returns the input levels with no masking. Each level passes through two flops, so a change at the inputs appears there after the second rising edge.
- R9: Writes to 0x00, 0x04, 0x30 and unused addresses change no state. Unused addresses read as zero.
- R10: Output n is registered. It goes high on the rising edge after its pending value becomes non-zero while bit 31 is set. That is the third edge after the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Write strobe for the register bank |
| busAddr | input | 8 | Byte address of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| irqLines | input | 32 | Level-sensitive peripheral interrupt lines |
| cpuIrq0 | output | 1 | CPU interrupt output 0 |
| cpuIrq1 | output | 1 | CPU interrupt output 1 |

## Verification
The line patterns mix enabled and disabled sources. Comparing the raw register with the two pending registers shows whether masking is applied and whether it leaks. The routing register is set so that each output carries a different source, which exposes swapped or merged routing. Dropping an input while it is enabled separates a true level follower from a latched pending bit. Toggling only bit 31 while the per-source bits stay set isolates the global gate from source 31. Single-cycle sampling around an input change pins down the two-flop delay on the raw levels and the one extra register on the outputs.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam logic [7:0] OFF_PEND0 = 8'h00;
  localparam logic [7:0] OFF_PEND1 = 8'h04;
  localparam logic [7:0] OFF_ROUTE = 8'h20;
  localparam logic [7:0] OFF_RAW   = 8'h30;
  localparam logic [7:0] OFF_ENSET = 8'h34;
  localparam logic [7:0] OFF_ENCLR = 8'h38;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PEND0,
    RD_PEND1,
    RD_ROUTE,
    RD_RAW,
    RD_EN
  } rdSel_e;

  typedef struct packed {
    logic   setEn;
    logic   clrEn;
    logic   wrRoute;
    rdSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/lic_ctrl.sv
module lic_ctrl
  import lic_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] A_PEND0 = ADDR_W'(OFF_PEND0);
  localparam logic [ADDR_W-1:0] A_PEND1 = ADDR_W'(OFF_PEND1);
  localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(OFF_ROUTE);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(OFF_ENSET);
  localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(OFF_ENCLR);

  always_comb begin
    strobe = '{setEn: 1'b0, clrEn: 1'b0, wrRoute: 1'b0, rdSel: RD_NONE};
    unique case (busAddr)
      A_PEND0: strobe.rdSel = RD_PEND0;
      A_PEND1: strobe.rdSel = RD_PEND1;
      A_ROUTE: begin
        strobe.rdSel   = RD_ROUTE;
        strobe.wrRoute = busWrEn;
      end
      A_RAW:   strobe.rdSel = RD_RAW;
      A_ENSET: begin
        strobe.rdSel = RD_EN;
        strobe.setEn = busWrEn;
      end
      A_ENCLR: strobe.clrEn = busWrEn;
      default: strobe.rdSel = RD_NONE;
    endcase
  end

  // R9
  one_write_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setEn, strobe.clrEn, strobe.wrRoute}));

  // R9
  no_strobe_without_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |-> !(strobe.setEn || strobe.clrEn || strobe.wrRoute));
endmodule

// File: rtl/lic_datapath.sv
module lic_datapath
  import lic_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int GLOBAL_BIT  = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] irqLines,
  output logic [NUM_SRC-1:0] rdData,
  output logic [1:0]         cpuIrq
);
  localparam int NUM_OUT = 2;

  logic [NUM_SRC-1:0] syncStg [SYNC_STAGES];
  logic [NUM_SRC-1:0] rawLvl;
  logic [NUM_SRC-1:0] enMask;
  logic [NUM_SRC-1:0] routeSel;
  logic [NUM_SRC-1:0] pend [NUM_OUT];
  logic               globalEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncStg[0] <= '0;
    else       syncStg[0] <= irqLines;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncStg[s] <= '0;
      else       syncStg[s] <= syncStg[s-1];
    end
  end

  assign rawLvl   = syncStg[SYNC_STAGES-1];
  assign globalEn = enMask[GLOBAL_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask   <= '0;
      routeSel <= '0;
    end else begin
      if (strobe.setEn)   enMask   <= enMask | wrData;
      if (strobe.clrEn)   enMask   <= enMask & ~wrData;
      if (strobe.wrRoute) routeSel <= wrData;
    end
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [NUM_SRC-1:0] routeMatch;
    assign routeMatch = (o == 0) ? ~routeSel : routeSel;
    assign pend[o]    = rawLvl & enMask & routeMatch;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cpuIrq[o] <= 1'b0;
      else       cpuIrq[o] <= globalEn && (pend[o] != '0);
    end

    // R4
    gate_blocks_out_chk: assert property (@(posedge clk) disable iff (!rstN)
      cpuIrq[o] |-> $past(enMask[GLOBAL_BIT]));
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_PEND0: rdData = pend[0];
      RD_PEND1: rdData = pend[1];
      RD_ROUTE: rdData = routeSel;
      RD_RAW:   rdData = rawLvl;
      RD_EN:    rdData = enMask;
      default:  rdData = '0;
    endcase
  end

  // R2
  set_takes_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setEn |=> ((enMask & $past(wrData)) == $past(wrData)));

  // R3
  clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrEn |=> ((enMask & $past(wrData)) == '0));

  // R9
  mask_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.setEn || strobe.clrEn) |=> $stable(enMask));

  // R5
  route_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pend[0] & pend[1]) == '0);

  // R4
  gate_off_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> (cpuIrq == 2'b00));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lic_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_SRC-1:0] busWrData,
  output logic [NUM_SRC-1:0] busRdData,
  input  logic [NUM_SRC-1:0] irqLines,
  output logic               cpuIrq0,
  output logic               cpuIrq1
);
  localparam int GLOBAL_BIT = NUM_SRC - 1;

  ctrlStrobe_t strobe;
  logic [1:0]  irqVec;

  lic_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  lic_datapath #(
    .NUM_SRC     (NUM_SRC),
    .SYNC_STAGES (SYNC_STAGES),
    .GLOBAL_BIT  (GLOBAL_BIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (busWrData),
    .irqLines (irqLines),
    .rdData   (busRdData),
    .cpuIrq   (irqVec)
  );

  assign cpuIrq0 = irqVec[0];
  assign cpuIrq1 = irqVec[1];
endmodule

// File: tb/lvl_irq_ctrl_bench.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] irqLines = '0;
  logic        cpuIrq0, cpuIrq1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          isOut;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t scoreQ[$];
  event  sampleEv;

  always #10 clk = ~clk;

  lvl_irq_ctrl u_lvl_irq_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqLines(irqLines),
    .cpuIrq0(cpuIrq0), .cpuIrq1(cpuIrq1)
  );

  // monitor: pops expected items and compares with the design
  initial begin
    forever begin
      @(sampleEv);
      while (scoreQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = scoreQ.pop_front();
        act = it.isOut ? {30'b0, cpuIrq1, cpuIrq0} : busRdData;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic expectRd(logic [7:0] a, logic [31:0] e, string tag);
    busAddr = a;
    #2;
    scoreQ.push_back('{isOut: 1'b0, exp: e, tag: tag});
    ->sampleEv;
    #1;
  endtask

  task automatic expectOut(logic [1:0] e, string tag);
    #2;
    scoreQ.push_back('{isOut: 1'b1, exp: {30'b0, e}, tag: tag});
    ->sampleEv;
    #1;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    expectRd(8'h34, 32'h0, "R1 enable mask after reset");
    expectRd(8'h20, 32'h0, "R1 routing after reset");
    expectOut(2'b00, "R1 outputs after reset");

    // R8 two-flop delay on raw levels
    @(negedge clk); irqLines = 32'h0000_00F5;
    step(1);
    expectRd(8'h30, 32'h0, "R8 raw after one edge");
    step(1);
    expectRd(8'h30, 32'h0000_00F5, "R8 raw after two edges");
    expectRd(8'h00, 32'h0, "R6 pending with nothing enabled");

    // R4 sources on, gate off
    wr(8'h34, 32'h0000_0005);
    expectRd(8'h34, 32'h0000_0005, "R2 enable readback");
    expectRd(8'h00, 32'h0000_0005, "R6 pending0 masked");
    step(2);
    expectOut(2'b00, "R4 gate off keeps outputs low");

    // R2 set keeps other bits; gate on
    wr(8'h34, 32'h8000_0010);
    expectRd(8'h34, 32'h8000_0015, "R2 set leaves zero bits unchanged");
    expectRd(8'h00, 32'h0000_0015, "R6 pending0 after set");
    step(1);
    expectOut(2'b01, "R4 gate on drives output 0");

    // R5 routing
    wr(8'h20, 32'h0000_0010);
    expectRd(8'h20, 32'h0000_0010, "R5 routing readback");
    expectRd(8'h00, 32'h0000_0005, "R5 pending0 after routing");
    expectRd(8'h04, 32'h0000_0010, "R5 pending1 after routing");
    step(1);
    expectOut(2'b11, "R5 both outputs high");

    // R7 immediate masking, R3 clear
    wr(8'h38, 32'h0000_0004);
    expectRd(8'h00, 32'h0000_0001, "R7 pending drops right after clear");
    expectRd(8'h34, 32'h8000_0011, "R3 clear only written bits");
    expectRd(8'h38, 32'h0, "R3 clear port reads zero");

    // R6 level follow
    @(negedge clk); irqLines = 32'h0000_0010;
    step(3);
    expectRd(8'h00, 32'h0, "R6 pending0 follows dropped line");
    expectRd(8'h04, 32'h0000_0010, "R6 pending1 still held by line");
    expectOut(2'b10, "R6 output 0 released by level");

    // R9 ignored writes
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    expectRd(8'h34, 32'h8000_0011, "R9 mask unchanged by read-only writes");
    expectRd(8'h20, 32'h0000_0010, "R9 routing unchanged by read-only writes");
    expectRd(8'h10, 32'h0, "R9 unused address reads zero");
    step(1);
    expectOut(2'b10, "R9 outputs unchanged");

    // R4 clear only the gate
    wr(8'h38, 32'h8000_0000);
    expectRd(8'h04, 32'h0000_0010, "R4 pending1 kept with gate off");
    step(1);
    expectOut(2'b00, "R4 gate cleared drops outputs");

    // R10 latency
    wr(8'h34, 32'h8000_0020);
    step(1);
    expectOut(2'b10, "R10 output 1 back with gate on");
    @(negedge clk); irqLines = 32'h0000_0030;
    step(2);
    expectOut(2'b10, "R10 output 0 low two edges after input");
    step(1);
    expectOut(2'b11, "R10 output 0 high on third edge");

    // R3 clear all
    wr(8'h38, 32'hFFFF_FFFF);
    expectRd(8'h34, 32'h0, "R3 clear all ones");
    step(1);
    expectOut(2'b00, "R3 outputs low after clear all");

    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule